// File: doc/BRIEF.md
# Tabulated Full-Bridge Gate Pulse Sequencer

This block produces the four gate commands for a single-phase full-bridge inverter. The switches are grouped into two diagonal pairs, S1/S2 and S3/S4. The block runs open loop from a tick prescaler and has two patterns. In the equal-pulse pattern, a pair is switched on and off at a fixed interval for a fixed number of intervals, and then the other pair takes over. In the sine-weighted pattern, the sequence is ten slots of 1 ms. In each slot the selected pair is held on for a width taken from a ten-entry symmetric table.

The pattern is chosen by a mode level that is captured during reset. In the sine-weighted pattern, a pair-select level picks which pair conducts for a whole ten-slot sequence. A leg guard sits in front of the output register. It turns any state that would close both switches of one leg into all-off. A one-cycle flag marks the last output cycle of each burst or sequence.

Top module: `gate_pulse_seq`

## Requirements
- R1: While `rst` is high, `gate_o` is 0000 and `cycle_end_o` is 0 one clock later. On the first clock edge with `rst` low, the outputs show the pattern of tick 0.
- R2: `gate_o` bit 0 is S1, bit 1 is S2, bit 2 is S3 and bit 3 is S4. S1 and S2 always carry the same value, and S3 and S4 always carry the same value. The two pairs are never on together.
- R3: In equal-pulse mode (`mode_i`=0), each on or off interval lasts EQ_DELAY ticks (20 by default). Every burst starts with its pair on.
- R4: In equal-pulse mode, a burst is 20 intervals long. The pair then hands over to the other pair, which starts on. The first burst after reset uses S1/S2, and the pairs alternate after that.
- R5: In equal-pulse mode, `pair_sel_i` has no effect on `gate_o`.
- R6: In sine-weighted mode (`mode_i`=1), every slot lasts SLOT_TICKS ticks (1000 ticks of 1 µs each = 1 ms by default). The selected pair is on for the first W ticks of the slot and all gates are off for the rest of the slot.
- R7: W, expressed in thousandths of a slot, is 216, 412, 566, 665, 700 for slots 0 to 4, and the same values mirrored for slots 5 to 9. After slot 9 the sequence starts again at slot 0.
- R8: `pair_sel_i`=0 selects S1/S2 and 1 selects S3/S4. The level is taken in the last reset cycle for the first sequence. For each later sequence it is taken at the clock edge that closes the previous sequence. Changes at any other time have no effect.
- R9: In the remainder of a slot, the S3/S4 commands are complemented. When S1/S2 is selected, this would close both legs (S1 with S4, S3 with S2), so the guard forces all four gates off.
- R10: `cycle_end_o` is high for exactly one cycle: the last output cycle of each 20-interval burst or ten-slot sequence.
- R11: `mode_i` is captured only during reset. Changing it while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Pattern select, captured in reset: 0 equal-pulse, 1 sine-weighted |
| pair_sel_i | input | 1 | Pair select for the sine-weighted pattern: 0 S1/S2, 1 S3/S4 |
| gate_o | output | 4 | Gate commands, bit 0 = S1 through bit 3 = S4 |
| cycle_end_o | output | 1 | One-cycle flag on the last cycle of a burst or sequence |

## Verification
The output register is one stage after the sequencer state. The value after rising edge t, counted from the first edge with reset low, therefore shows the state after t-1 ticks, and the bench runs with one tick per clock. At every rising edge the bench works out, from the requirements alone, the gates and flag due after that edge and queues them. A monitor pops each entry on the following falling edge and compares it, so every sample lands in the cycle its result is due. Select changes are placed mid-sequence, and the value due at the closing edge of each sequence is captured at that same edge, which tests both the ignore rule and the capture rule.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

    localparam int N_SLOTS    = 10;
    localparam int HALF_SLOTS = N_SLOTS / 2;
    localparam int EQ_BURST   = 20;
    localparam int PERMILLE   = 1000;

    typedef enum logic {
        MODE_EQUAL = 1'b0,
        MODE_SINE  = 1'b1
    } seq_mode_e;

    typedef enum logic {
        PAIR_A = 1'b0,   // S1/S2
        PAIR_B = 1'b1    // S3/S4
    } pair_e;

    typedef struct packed {
        logic s4;
        logic s3;
        logic s2;
        logic s1;
    } gates_t;

    // First half of the symmetric width table, in thousandths of a slot
    function automatic int half_width_pm(input int k);
        case (k)
            0:       return 216;
            1:       return 412;
            2:       return 566;
            3:       return 665;
            default: return 700;
        endcase
    endfunction

    // Width of slot 'slot' in ticks; second half mirrors the first
    function automatic int slot_on_ticks(input int slot, input int slot_ticks);
        int k;
        k = (slot < HALF_SLOTS) ? slot : (N_SLOTS - 1 - slot);
        return (half_width_pm(k) * slot_ticks) / PERMILLE;
    endfunction

    function automatic gates_t pair_gates(input pair_e p, input logic lvl);
        gates_t g;
        g    = '0;
        g.s1 = (p == PAIR_A) & lvl;
        g.s2 = (p == PAIR_A) & lvl;
        g.s3 = (p == PAIR_B) & lvl;
        g.s4 = (p == PAIR_B) & lvl;
        return g;
    endfunction

endpackage

// File: rtl/gate_tick_gen.sv
module gate_tick_gen #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/gate_equal_seq.sv
module gate_equal_seq
    import gate_seq_pkg::*;
#(
    parameter int DELAY_TICKS = 20,
    parameter int BURST       = EQ_BURST
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    output gates_t raw_o,
    output logic   last_o
);
    localparam int DW = $clog2(DELAY_TICKS + 1);
    localparam int BW = $clog2(BURST + 1);

    pair_e         pair_q;
    logic          lvl_q;
    logic [DW-1:0] dly_q;
    logic [BW-1:0] left_q;

    logic dly_done;
    logic burst_done;

    assign dly_done   = (dly_q == DW'(1));
    assign burst_done = (left_q == BW'(1));
    assign last_o     = dly_done & burst_done;
    assign raw_o      = pair_gates(pair_q, lvl_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= PAIR_A;
            lvl_q  <= 1'b1;
            dly_q  <= DW'(DELAY_TICKS);
            left_q <= BW'(BURST);
        end else if (step) begin
            if (!dly_done) begin
                dly_q <= dly_q - DW'(1);
            end else begin
                dly_q <= DW'(DELAY_TICKS);
                if (burst_done) begin
                    left_q <= BW'(BURST);
                    pair_q <= (pair_q == PAIR_A) ? PAIR_B : PAIR_A;
                    lvl_q  <= 1'b1;
                end else begin
                    left_q <= left_q - BW'(1);
                    lvl_q  <= ~lvl_q;
                end
            end
        end
    end
endmodule

// File: rtl/gate_sine_seq.sv
module gate_sine_seq
    import gate_seq_pkg::*;
#(
    parameter int SLOT_TICKS = 1000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  logic   pair_sel_i,
    output gates_t raw_o,
    output logic   last_o
);
    localparam int OW = $clog2(SLOT_TICKS);
    localparam int SW = $clog2(N_SLOTS);

    pair_e         pair_q;
    logic [SW-1:0] slot_q;
    logic [OW-1:0] off_q;

    logic   slot_end;
    logic   seq_end;
    logic   on_phase;
    gates_t on_g;

    assign slot_end = (off_q == OW'(SLOT_TICKS - 1));
    assign seq_end  = (slot_q == SW'(N_SLOTS - 1));
    assign last_o   = slot_end & seq_end;
    assign on_phase = int'(off_q) < slot_on_ticks(int'(slot_q), SLOT_TICKS);
    assign on_g     = pair_gates(pair_q, 1'b1);

    // On-time: selected pair only. Remainder: S3/S4 complemented.
    always_comb begin
        raw_o = on_g;
        if (!on_phase) begin
            raw_o.s3 = ~on_g.s3;
            raw_o.s4 = ~on_g.s4;
            raw_o.s1 = on_g.s1 & ~on_g.s1;
            raw_o.s2 = on_g.s2 & ~on_g.s2;
            if (pair_q == PAIR_A) begin
                raw_o.s1 = 1'b1;
                raw_o.s2 = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= pair_e'(pair_sel_i);
            slot_q <= '0;
            off_q  <= '0;
        end else if (step) begin
            if (!slot_end) begin
                off_q <= off_q + OW'(1);
            end else begin
                off_q <= '0;
                if (seq_end) begin
                    slot_q <= '0;
                    pair_q <= pair_e'(pair_sel_i);
                end else begin
                    slot_q <= slot_q + SW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/gate_leg_guard.sv
module gate_leg_guard
    import gate_seq_pkg::*;
(
    input  gates_t raw_i,
    output gates_t safe_o
);
    localparam int N_LEGS = 2;

    logic [3:0]        raw_v;
    logic [N_LEGS-1:0] short_v;

    assign raw_v = raw_i;

    // Leg l: upper switch bit 2*l, lower switch bit 3-2*l
    for (genvar l = 0; l < N_LEGS; l++) begin : g_leg
        assign short_v[l] = raw_v[2*l] & raw_v[3-2*l];
    end

    assign safe_o = (|short_v) ? gates_t'('0) : raw_i;
endmodule

// File: rtl/gate_pulse_seq.sv
module gate_pulse_seq
    import gate_seq_pkg::*;
#(
    parameter int TICK_DIV   = 50,
    parameter int SLOT_TICKS = 1000,
    parameter int EQ_DELAY   = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_i,
    input  logic       pair_sel_i,
    output logic [3:0] gate_o,
    output logic       cycle_end_o
);
    seq_mode_e mode_q;
    logic      tick;
    logic      step_eq;
    logic      step_sn;
    gates_t    raw_eq;
    gates_t    raw_sn;
    gates_t    raw_sel;
    gates_t    safe_g;
    logic      last_eq;
    logic      last_sn;
    logic      last_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= seq_mode_e'(mode_i);
        end
    end

    gate_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    assign step_eq = tick & (mode_q == MODE_EQUAL);
    assign step_sn = tick & (mode_q == MODE_SINE);

    gate_equal_seq #(.DELAY_TICKS(EQ_DELAY), .BURST(EQ_BURST)) u_equal (
        .clk    (clk),
        .rst    (rst),
        .step   (step_eq),
        .raw_o  (raw_eq),
        .last_o (last_eq)
    );

    gate_sine_seq #(.SLOT_TICKS(SLOT_TICKS)) u_sine (
        .clk        (clk),
        .rst        (rst),
        .step       (step_sn),
        .pair_sel_i (pair_sel_i),
        .raw_o      (raw_sn),
        .last_o     (last_sn)
    );

    assign raw_sel  = (mode_q == MODE_SINE) ? raw_sn  : raw_eq;
    assign last_sel = (mode_q == MODE_SINE) ? last_sn : last_eq;

    gate_leg_guard u_guard (
        .raw_i  (raw_sel),
        .safe_o (safe_g)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_o      <= '0;
            cycle_end_o <= 1'b0;
        end else begin
            gate_o      <= safe_g;
            cycle_end_o <= tick & last_sel;
        end
    end
endmodule

// File: rtl/gate_pulse_seq_chk.sv
module gate_pulse_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] gate_o,
    input logic       cycle_end_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (gate_o == 4'b0000 && !cycle_end_o)); // R1

    AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (rst)
        (gate_o[0] == gate_o[1]) && (gate_o[2] == gate_o[3])); // R2

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !((gate_o[0] | gate_o[1]) && (gate_o[2] | gate_o[3]))); // R2

    AST_LEG_SAFE: assert property (@(posedge clk) disable iff (rst)
        !(gate_o[0] & gate_o[3]) && !(gate_o[2] & gate_o[1])); // R9

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (rst)
        cycle_end_o |=> !cycle_end_o); // R10
endmodule

bind gate_pulse_seq gate_pulse_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .gate_o      (gate_o),
    .cycle_end_o (cycle_end_o)
);

// File: tb/test_gate_pulse_seq.sv
module test_gate_pulse_seq;
    localparam int SLOT  = 1000;
    localparam int DLY   = 20;
    localparam int BURST = 20 * DLY;
    localparam int SEQ   = 10 * SLOT;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic       sel = 1'b0;
    logic [3:0] gate;
    logic       cend;

    int n_chk = 0;
    int n_fail = 0;
    int t_run = 0;
    logic mode_cap = 1'b0;
    logic sel_cur = 1'b0;
    bit finished = 0;

    logic [3:0] q_g[$];
    logic       q_e[$];
    string      q_tag[$];

    always #10 clk = ~clk;

    gate_pulse_seq #(.TICK_DIV(1), .SLOT_TICKS(SLOT), .EQ_DELAY(DLY)) i_gate_pulse_seq (
        .clk         (clk),
        .rst         (rst),
        .mode_i      (mode),
        .pair_sel_i  (sel),
        .gate_o      (gate),
        .cycle_end_o (cend)
    );

    function automatic int width_pm(input int s);
        case (s)
            0, 9: return 216;
            1, 8: return 412;
            2, 7: return 566;
            3, 6: return 665;
            default: return 700;
        endcase
    endfunction

    task automatic push_exp(input logic [3:0] g, input logic e, input string tag);
        q_g.push_back(g);
        q_e.push_back(e);
        q_tag.push_back(tag);
    endtask

    // Driver side of the scoreboard: expected result due after this edge
    always @(posedge clk) begin
        if (rst) begin
            t_run    = 0;
            mode_cap = mode;   // R11: captured in reset only
            sel_cur  = sel;    // R8: first sequence uses last reset level
            push_exp(4'b0000, 1'b0, "R1");
        end else begin
            int m;
            m = t_run;
            if (!mode_cap) begin
                int j;
                logic [3:0] g;
                j = (m % BURST) / DLY;
                g = 4'b0000;
                if ((j % 2) == 0) g = ((m / BURST) % 2 == 0) ? 4'b0011 : 4'b1100;
                push_exp(g, (m % BURST) == BURST - 1, "R2 R3 R4 R5 R11");
            end else begin
                int s;
                int o;
                logic [3:0] g;
                s = (m / SLOT) % 10;
                o = m % SLOT;
                g = 4'b0000;
                if (o < (width_pm(s) * SLOT) / 1000) g = sel_cur ? 4'b1100 : 4'b0011;
                push_exp(g, (m % SEQ) == SEQ - 1, "R2 R6 R7 R8 R9 R11");
                if ((m % SEQ) == SEQ - 1) sel_cur = sel;   // R8 capture at closing edge
            end
            t_run = t_run + 1;
        end
    end

    // Monitor side: compare away from the active edge
    always @(negedge clk) begin
        if (q_g.size() > 0) begin
            logic [3:0] eg;
            logic       ee;
            string      tg;
            eg = q_g.pop_front();
            ee = q_e.pop_front();
            tg = q_tag.pop_front();
            n_chk++;
            if (gate !== eg) begin
                n_fail++;
                $display("FAIL %s: gate_o=%b expected %b at t=%0d", tg, gate, eg, t_run);
            end
            n_chk++;
            if (cend !== ee) begin
                n_fail++;
                $display("FAIL R10 (%s): cycle_end_o=%b expected %b at t=%0d", tg, cend, ee, t_run);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        // Equal-pulse run; select and mode changes must be ignored (R5, R11)
        mode = 1'b0; sel = 1'b1; rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (300) @(negedge clk);
        sel = 1'b0; mode = 1'b1;
        repeat (300) @(negedge clk);
        sel = 1'b1;
        repeat (700) @(negedge clk);

        // Sine-weighted run, S3/S4 first, then S1/S2 (guard, R9), then S3/S4
        rst = 1'b1; mode = 1'b1; sel = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (4000) @(negedge clk);
        sel = 1'b0; mode = 1'b0;       // R8: no effect until sequence closes
        repeat (10000) @(negedge clk);
        sel = 1'b1;
        repeat (16010) @(negedge clk);
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end
endmodule